// File: doc/BRIEF.md
# Four-State Address Pin Decoder

This block works out how each of two address straps is wired on the board. A strap can be tied low, tied high, or tied to either of the two serial bus lines (clock or data). While the bus is carrying a transmission, the block samples each strap once per clock. It compares each sample with the clock line and with the data line at the same instant. When the transmission ends, it commits a new class for each strap. It does this on every transmission, whichever device on the bus is being addressed.

From the two committed classes it forms three results. The first is the 7-bit target address it answers to. The second is the power-up default level for the two pairs of output pins. The third is the enable for the two pairs of input pullups. Before any transmission has been seen, both straps are taken to be tied high. This matches an idle bus, where the clock and data lines sit high.

The strap levels, the bus lines and the transmission window arrive already synchronised to `clk`.

Top module: `addr_pin_decoder`

## Requirements
- R1: While reset is held, and after it until the first transmission window closes, slaveAddr is 7'b1101101, outDefault is 4'b1111 and pullupEn is 2'b11 (both straps are treated as tied high).
- R2: slaveAddr[6:4] is always 3'b110.
- R3: slaveAddr[3:2] is set by the strap on padAd2: clock line gives 2'b00, data line gives 2'b01, tied low gives 2'b10, tied high gives 2'b11.
- R4: slaveAddr[1:0] is set by the strap on padAd0: tied low gives 2'b00, tied high gives 2'b01, clock line gives 2'b10, data line gives 2'b11.
- R5: A strap is classed as the clock line when two conditions hold: it equals sclIn on every clock sample in the window, and sclIn was seen both high and low in that window. The same rule with sdaIn classes a strap as the data line.
- R6: A strap that is not classed as a bus line is classed by its level at the last sample of the window: 1 gives tied high and 0 gives tied low. This includes a strap that follows a bus line which never toggled.
- R7: The outputs change only at the first clock edge at which xferActive is sampled low after being high. They are held throughout an open window.
- R8: Every window replaces the previous classes, so a strap that changes its wiring is reported correctly after the next window.
- R9: outDefault[1:0] and pullupEn[0] are all 1 when the padAd0 class is anything other than tied low, and all 0 when it is tied low.
- R10: outDefault[3:2] and pullupEn[1] follow the same rule for the padAd2 class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| padAd0 | input | 1 | Synchronised level of the low-order address strap |
| padAd2 | input | 1 | Synchronised level of the high-order address strap |
| sclIn | input | 1 | Synchronised bus clock line |
| sdaIn | input | 1 | Synchronised bus data line |
| xferActive | input | 1 | High while a bus transmission is in progress |
| slaveAddr | output | 7 | Decoded 7-bit target address |
| outDefault | output | 4 | Default output levels, {O7,O6,O1,O0} |
| pullupEn | output | 2 | Pullup enables, bit 1 for I4/I5, bit 0 for I2/I3 |

## Verification
The results of a window become valid one clock after the window closes. That is the edge that first samples xferActive low, and the outputs are readable at the falling edge that follows. The driver stamps each expected item with that cycle number, and the monitor compares the item at exactly that falling edge. For every sample inside an open window, the bench also checks that the outputs still equal the last committed expectation. Inputs are driven and outputs are read on falling edges, so no check races the rising edge that updates the design.

// File: rtl/addr_pin_pkg.sv
package addr_pin_pkg;

  typedef enum logic [1:0] {
    CLS_GND = 2'd0,
    CLS_VDD = 2'd1,
    CLS_SCL = 2'd2,
    CLS_SDA = 2'd3
  } pinClass_t;

  typedef struct packed {
    logic clr;     // first sample of a window: restart accumulation
    logic smp;     // further sample inside the window
    logic commit;  // window just closed: publish new classes
  } ctlStrobe_t;

  // Low-order field: code equals the class encoding.
  function automatic logic [1:0] ad0Field(pinClass_t c);
    return c;
  endfunction

  // High-order field: bus-line classes come first in its numbering.
  function automatic logic [1:0] ad2Field(pinClass_t c);
    return c ^ 2'b10;
  endfunction

  function automatic pinClass_t classify(logic matchScl, logic matchSda,
                                         logic sclToggled, logic sdaToggled,
                                         logic lastLvl);
    if (matchScl && sclToggled)      return CLS_SCL;
    else if (matchSda && sdaToggled) return CLS_SDA;
    else if (lastLvl)                return CLS_VDD;
    else                             return CLS_GND;
  endfunction

endpackage

// File: rtl/addr_pin_ctrl.sv
module addr_pin_ctrl
  import addr_pin_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       xferActive,
  output ctlStrobe_t strb
);

  logic activeQ;

  always_ff @(posedge clk) begin
    if (!rstN) activeQ <= 1'b0;
    else       activeQ <= xferActive;
  end

  always_comb begin
    strb.clr    = xferActive & ~activeQ;
    strb.smp    = xferActive &  activeQ;
    strb.commit = ~xferActive & activeQ;
  end

endmodule

// File: rtl/addr_pin_dp.sv
module addr_pin_dp
  import addr_pin_pkg::*;
#(
  parameter int NUM_PINS = 2
)(
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strb,
  input  logic [NUM_PINS-1:0] pinLvl,
  input  logic                sclIn,
  input  logic                sdaIn,
  output pinClass_t           pinCls [NUM_PINS]
);

  logic sclHiSeen, sclLoSeen, sdaHiSeen, sdaLoSeen;

  // Bus-line activity inside the current window, shared by all straps.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclHiSeen <= 1'b0;
      sclLoSeen <= 1'b0;
      sdaHiSeen <= 1'b0;
      sdaLoSeen <= 1'b0;
    end else if (strb.clr) begin
      sclHiSeen <= sclIn;
      sclLoSeen <= ~sclIn;
      sdaHiSeen <= sdaIn;
      sdaLoSeen <= ~sdaIn;
    end else if (strb.smp) begin
      sclHiSeen <= sclHiSeen | sclIn;
      sclLoSeen <= sclLoSeen | ~sclIn;
      sdaHiSeen <= sdaHiSeen | sdaIn;
      sdaLoSeen <= sdaLoSeen | ~sdaIn;
    end
  end

  logic sclToggled, sdaToggled;
  assign sclToggled = sclHiSeen & sclLoSeen;
  assign sdaToggled = sdaHiSeen & sdaLoSeen;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic      matchScl, matchSda, lastLvl;
    pinClass_t clsQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        matchScl <= 1'b0;
        matchSda <= 1'b0;
        lastLvl  <= 1'b1;
        clsQ     <= CLS_VDD;
      end else begin
        if (strb.clr) begin
          matchScl <= (pinLvl[p] == sclIn);
          matchSda <= (pinLvl[p] == sdaIn);
          lastLvl  <= pinLvl[p];
        end else if (strb.smp) begin
          matchScl <= matchScl & (pinLvl[p] == sclIn);
          matchSda <= matchSda & (pinLvl[p] == sdaIn);
          lastLvl  <= pinLvl[p];
        end
        if (strb.commit)
          clsQ <= classify(matchScl, matchSda, sclToggled, sdaToggled, lastLvl);
      end
    end

    assign pinCls[p] = clsQ;
  end

endmodule

// File: rtl/addr_pin_decoder.sv
module addr_pin_decoder
  import addr_pin_pkg::*;
#(
  parameter logic [2:0] ADDR_PREFIX = 3'b110
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       padAd0,
  input  logic       padAd2,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       xferActive,
  output logic [6:0] slaveAddr,
  output logic [3:0] outDefault,
  output logic [1:0] pullupEn
);

  localparam int NUM_PINS = 2;
  localparam int IDX_AD0  = 0;
  localparam int IDX_AD2  = 1;

  ctlStrobe_t strb;
  pinClass_t  pinCls [NUM_PINS];

  addr_pin_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .xferActive (xferActive),
    .strb       (strb)
  );

  addr_pin_dp #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .pinLvl ({padAd2, padAd0}),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .pinCls (pinCls)
  );

  logic ad0High, ad2High;
  assign ad0High = (pinCls[IDX_AD0] != CLS_GND);
  assign ad2High = (pinCls[IDX_AD2] != CLS_GND);

  assign slaveAddr  = {ADDR_PREFIX, ad2Field(pinCls[IDX_AD2]), ad0Field(pinCls[IDX_AD0])};
  assign outDefault = {{2{ad2High}}, {2{ad0High}}};
  assign pullupEn   = {ad2High, ad0High};

endmodule

// File: rtl/addr_pin_decoder_chk.sv
module addr_pin_decoder_chk (
  input logic       clk,
  input logic       rstN,
  input logic       xferActive,
  input logic [6:0] slaveAddr,
  input logic [3:0] outDefault,
  input logic [1:0] pullupEn
);

  p_reset_value_r1: assert property (@(posedge clk)
    $rose(rstN) |-> (slaveAddr == 7'b1101101 && outDefault == 4'hF && pullupEn == 2'b11));

  p_fixed_prefix_r2: assert property (@(posedge clk) disable iff (!rstN)
    slaveAddr[6:4] == 3'b110);

  p_hold_in_window_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(xferActive) |-> ($stable(slaveAddr) && $stable(outDefault) && $stable(pullupEn)));

  p_low_pair_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pullupEn[0] == (slaveAddr[1:0] != 2'b00)) && (outDefault[1:0] == {2{pullupEn[0]}}));

  p_high_pair_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pullupEn[1] == (slaveAddr[3:2] != 2'b10)) && (outDefault[3:2] == {2{pullupEn[1]}}));

endmodule

bind addr_pin_decoder addr_pin_decoder_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .xferActive (xferActive),
  .slaveAddr  (slaveAddr),
  .outDefault (outDefault),
  .pullupEn   (pullupEn)
);

// File: tb/sim_addr_pin_decoder.sv
`timescale 1ns/1ps
module sim_addr_pin_decoder;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, padAd0, padAd2, sclIn, sdaIn, xferActive;
  logic [6:0] slaveAddr;
  logic [3:0] outDefault;
  logic [1:0] pullupEn;

  addr_pin_decoder u0 (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  longint cyc = 0;
  always @(posedge clk) cyc++;

  typedef struct {
    longint     due;
    logic [6:0] addr;
    logic [3:0] dflt;
    logic [1:0] pull;
    string      tag;
  } exp_t;
  exp_t sbq[$];
  exp_t cur;

  logic [6:0] curAddr;
  logic [3:0] curDflt;
  logic [1:0] curPull;

  // Class codes used by the bench: 0 low, 1 high, 2 clock line, 3 data line.
  function automatic logic [1:0] expAd0(int c);
    case (c)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic [1:0] expAd2(int c);
    case (c)
      2: return 2'b00;
      3: return 2'b01;
      0: return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  // A strap on a bus line that never toggled falls back to that line's held level.
  function automatic int effClass(int c, int sclMode, int sdaMode);
    if (c == 2 && sclMode != 0) return (sclMode == 1) ? 1 : 0;
    if (c == 3 && sdaMode != 0) return (sdaMode == 1) ? 1 : 0;
    return c;
  endfunction

  function automatic logic busVal(int mode, int i, bit isData);
    if (mode == 1) return 1'b1;
    if (mode == 2) return 1'b0;
    return isData ? i[1] : i[0];
  endfunction

  function automatic logic pinVal(int c, logic s, logic d);
    case (c)
      0: return 1'b0;
      1: return 1'b1;
      2: return s;
      default: return d;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pushExp(int c0, int c2, string tag);
    exp_t e;
    e.due  = cyc + 1;
    e.addr = {3'b110, expAd2(c2), expAd0(c0)};
    e.dflt = {{2{c2 != 0}}, {2{c0 != 0}}};
    e.pull = {c2 != 0, c0 != 0};
    e.tag  = tag;
    sbq.push_back(e);
    curAddr = e.addr;
    curDflt = e.dflt;
    curPull = e.pull;
  endtask

  // Monitor: compare each expected item at its due falling edge.
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due == cyc) begin
      cur = sbq.pop_front();
      chk({cur.tag, " address"}, 32'(slaveAddr), 32'(cur.addr));
      chk("R2 fixed prefix", 32'(slaveAddr[6:4]), 32'(3'b110));
      chk({cur.tag, " R9 R10 defaults"}, 32'(outDefault), 32'(cur.dflt));
      chk({cur.tag, " R9 R10 pullups"}, 32'(pullupEn), 32'(cur.pull));
    end
  end

  task automatic holdCheck();
    chk("R7 hold in window", 32'({slaveAddr, outDefault, pullupEn}),
        32'({curAddr, curDflt, curPull}));
  endtask

  task automatic closeWindow(int c0, int c2, string tag);
    @(negedge clk);
    xferActive = 1'b0;
    sclIn = 1'b1;
    sdaIn = 1'b1;
    pushExp(c0, c2, tag);
    @(negedge clk);
  endtask

  task automatic doWindow(int c0, int c2, int sclMode, int sdaMode, string tag);
    for (int i = 0; i < 6; i++) begin
      logic s, d;
      @(negedge clk);
      holdCheck();
      s = busVal(sclMode, i, 1'b0);
      d = busVal(sdaMode, i, 1'b1);
      sclIn = s;
      sdaIn = d;
      padAd0 = pinVal(c0, s, d);
      padAd2 = pinVal(c2, s, d);
      xferActive = 1'b1;
    end
    closeWindow(effClass(c0, sclMode, sdaMode), effClass(c2, sclMode, sdaMode), tag);
  endtask

  // padAd0 follows an explicit pattern; padAd2 is tied high.
  task automatic patWindow(logic [5:0] pat, int expC0, string tag);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      holdCheck();
      sclIn = i[0];
      sdaIn = i[1];
      padAd0 = pat[i];
      padAd2 = 1'b1;
      xferActive = 1'b1;
    end
    closeWindow(expC0, 1, tag);
  endtask

  initial begin
    rstN = 1'b0;
    xferActive = 1'b0;
    sclIn = 1'b1;
    sdaIn = 1'b1;
    padAd0 = 1'b0;
    padAd2 = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 address in reset", 32'(slaveAddr), 32'(7'b1101101));
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 address after reset", 32'(slaveAddr), 32'(7'b1101101));
    chk("R1 defaults after reset", 32'(outDefault), 32'(4'hF));
    chk("R1 pullups after reset", 32'(pullupEn), 32'(2'b11));
    curAddr = 7'b1101101;
    curDflt = 4'hF;
    curPull = 2'b11;

    // Every wiring pair, changing on each window (R3 R4 R5 R8).
    for (int c2 = 0; c2 < 4; c2++)
      for (int c0 = 0; c0 < 4; c0++)
        doWindow(c0, c2, 0, 0, "R3 R4 R5 R8 pair");

    // Bus lines held static: strap falls back to its level (R6).
    doWindow(2, 3, 1, 2, "R6 idle bus high/low");
    doWindow(3, 2, 1, 2, "R6 idle bus mixed");
    doWindow(2, 2, 2, 0, "R6 clock held low");

    // Partial bus-line match then divergence (R6), then back to clock line (R5 R8).
    patWindow(6'b001010, 0, "R6 diverge ends low");
    patWindow(6'b111010, 1, "R6 diverge ends high");
    patWindow(6'b101010, 2, "R5 R8 clock follow");

    repeat (2) @(negedge clk);
    chk("R7 idle after windows", 32'({slaveAddr, outDefault, pullupEn}),
        32'({curAddr, curDflt, curPull}));
    chk("R8 scoreboard drained", 32'(sbq.size()), 32'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule